// File: doc/BRIEF.md
# Nibble-Link Test Vector Wrapper

This block connects a cryptographic core under test to a controller over a narrow full-duplex link. The link moves 4 bits per transfer in each direction, and each direction has a valid/ready handshake. The controller sends a test vector as a series of commands.

- **Loading inputs.** Input commands carry public, secret or random payload bytes. The wrapper packs those nibbles into wide words and pushes each word into a first-word-fall-through FIFO for that kind of data.
- **Running the core.** The core is held in reset while its inputs are loaded. A start command releases the reset. The core then drains the input FIFOs over valid/ready streams and writes its results into an output FIFO.
- **Returning results.** Once the output FIFO holds at least the programmed number of result bytes, the wrapper sends exactly that many bytes back over the link as nibbles. It then puts the core back in reset, discards any leftover output and waits for the next vector.

Each command begins with one header nibble:

| Header | Meaning | Followed by |
|---|---|---|
| 0x1 | Public data | 16-bit byte length, then payload |
| 0x2 | Secret data | 16-bit byte length, then payload |
| 0x3 | Random data | 16-bit byte length, then payload |
| 0x4 | Expected result byte count | 16-bit byte count, no payload |
| 0x8 | Start | nothing |

Every 16-bit value is sent as four nibbles, most significant nibble first. Each payload byte is sent as two nibbles, high nibble first.

Top module: `vector_link_wrapper`

## Requirements
- R1: After reset, core_rst is 1, out_valid is 0, in_ready is 1, and pdi_valid, sdi_valid and rdi_valid are all 0.
- R2: Header 0x1 (public) or 0x2 (secret) is followed by a 16-bit byte length L as four nibbles, most significant first, and then 2·L payload nibbles. Payload nibbles fill a word from its most significant nibble downward. Each full word is pushed to the public or secret FIFO, and its head word appears on pdi_data/pdi_valid or sdi_data/sdi_valid with no read needed.
- R3: When the declared length ends partway through a word, the unfilled low-order nibbles of that word are zero and the word is pushed.
- R4: A header nibble other than 0x1, 0x2, 0x3, 0x4 or 0x8 is accepted and has no effect.
- R5: With RAND_WORDS = 0, a header 0x3 command and its payload are accepted and discarded, and rdi_valid stays 0.
- R6: core_rst stays 1 until a header 0x8 is accepted, and it is then 0. Link input is accepted only while core_rst is 1, so in_ready is 0 while the core runs.
- R7: A word moves on a core-side stream only on a clock edge where its valid and ready are both 1. Consumed public and secret words leave their FIFOs, and result words enter the output FIFO.
- R8: Header 0x4 sets an expected result byte count E (16 bits). Sending does not begin until the output FIFO holds at least E bytes.
- R9: Exactly 2·E nibbles are sent, each output word most significant nibble first. out_nib is held unchanged while out_valid is 1 and out_ready is 0.
- R10: After the last nibble is accepted, core_rst returns to 1, E is cleared, output not yet sent is discarded, and the next header is accepted.
- R11: While the destination FIFO is full, in_ready is 0 for a payload nibble that would complete a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_nib | input | 4 | Nibble from the controller |
| in_valid | input | 1 | in_nib is valid |
| in_ready | output | 1 | Wrapper accepts in_nib |
| out_nib | output | 4 | Result nibble to the controller |
| out_valid | output | 1 | out_nib is valid |
| out_ready | input | 1 | Controller accepts out_nib |
| core_rst | output | 1 | Reset for the core, active high |
| pdi_data | output | PW | Head of the public-data FIFO |
| pdi_valid | output | 1 | Public-data FIFO not empty |
| pdi_ready | input | 1 | Core takes the public word |
| sdi_data | output | SW | Head of the secret-data FIFO |
| sdi_valid | output | 1 | Secret-data FIFO not empty |
| sdi_ready | input | 1 | Core takes the secret word |
| rdi_data | output | RW | Head of the random-data FIFO (zero when absent) |
| rdi_valid | output | 1 | Random-data FIFO not empty |
| rdi_ready | input | 1 | Core takes the random word |
| do_data | input | OW | Result word from the core |
| do_valid | input | 1 | do_data is valid |
| do_ready | output | 1 | Output FIFO has room |

## Verification
The bench targets the following corner cases:

- **Short secret payload.** The final word is only partly filled. A wrapper that skipped the zero padding, or that never pushed the partial word, would leave the core waiting or feed it stale nibbles.
- **Unknown headers and random data with no random path.** These test that ignored traffic cannot shift the parser out of step. If it did, the next length field would be misread.
- **Held-back second result word.** The core releases only one of two result words. A transmitter that started early would send half a result.
- **Expected count smaller than the output.** The wrapper must stop at the exact nibble count and drop the extra word. Failing to drop it would corrupt the next vector.
- **Full public FIFO.** This must stall the link rather than overwrite a queued word.

// File: rtl/vlw_pkg.sv
package vlw_pkg;
   localparam logic [3:0] HDR_PUB = 4'h1;
   localparam logic [3:0] HDR_SEC = 4'h2;
   localparam logic [3:0] HDR_RND = 4'h3;
   localparam logic [3:0] HDR_EXP = 4'h4;
   localparam logic [3:0] HDR_GO  = 4'h8;

   typedef enum logic [2:0] {ST_HDR, ST_LEN, ST_PAY, ST_RUN, ST_TX} link_st_e;
   typedef enum logic [1:0] {DST_PUB, DST_SEC, DST_RND, DST_EXP} dest_e;
endpackage

// File: rtl/vlw_fifo.sv
module vlw_fifo #(
   parameter int W     = 128,
   parameter int LOG2D = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   output logic             full,
   input  logic             rd_en,
   output logic [W-1:0]     rd_data,
   output logic             empty,
   output logic [LOG2D:0]   count
);
   localparam int D = 1 << LOG2D;

   if (LOG2D < 1 || W < 1) begin : g_bad_cfg
      $error("vlw_fifo: LOG2D and W must be at least 1");
   end

   logic [W-1:0]       mem [D];
   logic [LOG2D-1:0]   wp, rp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; count <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; count <= '0;
      end else begin
         if (wr_en) wp <= wp + 1'b1;
         if (rd_en) rp <= rp + 1'b1;
         count <= count + (LOG2D+1)'(wr_en) - (LOG2D+1)'(rd_en);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   assign rd_data = mem[rp];
   assign empty   = (count == '0);
   assign full    = (count == (LOG2D+1)'(D));

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);
   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
endmodule

// File: rtl/vlw_pack.sv
module vlw_pack #(
   parameter  int MAXW = 128,
   localparam int NN   = MAXW / 4,
   localparam int IW   = $clog2(NN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             flush,
   input  logic [3:0]       nib,
   input  logic [IW-1:0]    word_nibs,
   output logic [MAXW-1:0]  word,
   output logic             word_end
);
   logic [IW-1:0]   idx;
   logic [MAXW-1:0] acc;

   always_comb begin
      word = acc;
      for (int i = 0; i < NN; i++) begin
         if (idx == IW'(i)) word[MAXW-4-4*i +: 4] = nib;
      end
   end

   assign word_end = (idx == word_nibs - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0; acc <= '0;
      end else if (flush) begin
         idx <= '0; acc <= '0;
      end else if (take) begin
         idx <= idx + 1'b1; acc <= word;
      end
   end

   // R3
   pad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (idx == '0));
endmodule

// File: rtl/vlw_unpack.sv
module vlw_unpack #(
   parameter  int W  = 128,
   parameter  int BW = 17,
   localparam int NN = W / 4,
   localparam int IW = $clog2(NN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [BW-1:0] budget,
   input  logic [W-1:0]  src_data,
   input  logic          src_empty,
   output logic          src_pop,
   output logic [3:0]    out_nib,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          finished
);
   logic [BW-1:0] left;
   logic [IW-1:0] have;
   logic [W-1:0]  sh;
   logic          xfer;

   assign src_pop   = (left != '0) && (have == '0) && !src_empty;
   assign out_valid = (have != '0);
   assign out_nib   = sh[W-1 -: 4];
   assign xfer      = out_valid && out_ready;
   assign finished  = xfer && (left == BW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0; have <= '0; sh <= '0;
      end else if (start) begin
         left <= budget; have <= '0;
      end else if (src_pop) begin
         sh <= src_data; have <= IW'(NN);
      end else if (xfer) begin
         sh   <= sh << 4;
         left <= left - 1'b1;
         have <= finished ? '0 : have - 1'b1;
      end
   end

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_nib)));
endmodule

// File: rtl/vector_link_wrapper.sv
module vector_link_wrapper
   import vlw_pkg::*;
#(
   parameter int PW         = 128,
   parameter int SW         = 128,
   parameter int OW         = 128,
   parameter int RW         = 64,
   parameter int PUB_LOG2D  = 1,
   parameter int SEC_LOG2D  = 1,
   parameter int OUT_LOG2D  = 1,
   parameter int RND_LOG2D  = 3,
   parameter int RAND_WORDS = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    in_nib,
   input  logic          in_valid,
   output logic          in_ready,
   output logic [3:0]    out_nib,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          core_rst,
   output logic [PW-1:0] pdi_data,
   output logic          pdi_valid,
   input  logic          pdi_ready,
   output logic [SW-1:0] sdi_data,
   output logic          sdi_valid,
   input  logic          sdi_ready,
   output logic [RW-1:0] rdi_data,
   output logic          rdi_valid,
   input  logic          rdi_ready,
   input  logic [OW-1:0] do_data,
   input  logic          do_valid,
   output logic          do_ready
);
   localparam int MAXW = (PW > SW) ? ((PW > RW) ? PW : RW) : ((SW > RW) ? SW : RW);
   localparam int NIW  = $clog2(MAXW/4 + 1);
   localparam int OCW  = OUT_LOG2D + 1;

   if ((PW % 8) != 0 || (SW % 8) != 0 || (OW % 8) != 0 || (RW % 8) != 0) begin : g_bad_w
      $error("vector_link_wrapper: all word widths must be whole bytes");
   end

   link_st_e        state;
   dest_e           dst;
   logic [11:0]     len_sh;
   logic [1:0]      len_cnt;
   logic [16:0]     rem;
   logic [15:0]     exp_bytes;
   logic [15:0]     len_full;
   logic            take, last, word_end, flush, dst_full, fill_ok, unp_start, unp_fin;
   logic [MAXW-1:0] word;
   logic [NIW-1:0]  word_nibs;
   logic            pdi_full, pdi_empty, sdi_full, sdi_empty, rdi_full;
   logic            out_full, out_empty, out_pop;
   logic [OW-1:0]   out_head;
   logic [OCW-1:0]  out_cnt;
   logic [PUB_LOG2D:0] pub_cnt_unused;
   logic [SEC_LOG2D:0] sec_cnt_unused;

   assign len_full = {len_sh, in_nib};
   assign last     = (rem == 17'd1);

   always_comb begin
      case (dst)
         DST_SEC: begin word_nibs = NIW'(SW/4); dst_full = sdi_full; end
         DST_RND: begin word_nibs = NIW'(RW/4); dst_full = rdi_full; end
         default: begin word_nibs = NIW'(PW/4); dst_full = pdi_full; end
      endcase
      case (state)
         ST_HDR, ST_LEN: in_ready = 1'b1;
         ST_PAY:         in_ready = !((word_end || last) && dst_full);
         default:        in_ready = 1'b0;
      endcase
   end

   assign take      = in_valid && in_ready;
   assign flush     = take && (state == ST_PAY) && (word_end || last);
   assign fill_ok   = (32'(out_cnt) * (OW/8)) >= 32'(exp_bytes);
   assign unp_start = (state == ST_RUN) && (exp_bytes != '0) && fill_ok;
   assign core_rst  = !((state == ST_RUN) || (state == ST_TX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HDR; dst <= DST_PUB; len_sh <= '0; len_cnt <= '0;
         rem <= '0; exp_bytes <= '0;
      end else begin
         case (state)
            ST_HDR: if (take) begin
               case (in_nib)
                  HDR_PUB: begin dst <= DST_PUB; state <= ST_LEN; end
                  HDR_SEC: begin dst <= DST_SEC; state <= ST_LEN; end
                  HDR_RND: begin dst <= DST_RND; state <= ST_LEN; end
                  HDR_EXP: begin dst <= DST_EXP; state <= ST_LEN; end
                  HDR_GO:  state <= ST_RUN;
                  default: ;
               endcase
            end
            ST_LEN: if (take) begin
               len_sh  <= len_full[11:0];
               len_cnt <= len_cnt + 1'b1;
               if (len_cnt == 2'd3) begin
                  if (dst == DST_EXP) begin
                     exp_bytes <= len_full;
                     state     <= ST_HDR;
                  end else if (len_full == '0) begin
                     state <= ST_HDR;
                  end else begin
                     rem   <= {len_full, 1'b0};
                     state <= ST_PAY;
                  end
               end
            end
            ST_PAY: if (take) begin
               rem <= rem - 1'b1;
               if (last) state <= ST_HDR;
            end
            ST_RUN: begin
               if (exp_bytes == '0) state <= ST_HDR;
               else if (fill_ok)    state <= ST_TX;
            end
            ST_TX: if (unp_fin) begin
               state     <= ST_HDR;
               exp_bytes <= '0;
            end
            default: state <= ST_HDR;
         endcase
      end
   end

   vlw_pack #(.MAXW(MAXW)) u_pack (
      .clk(clk), .rst_n(rst_n), .take(take && (state == ST_PAY)), .flush(flush),
      .nib(in_nib), .word_nibs(word_nibs), .word(word), .word_end(word_end));

   vlw_fifo #(.W(PW), .LOG2D(PUB_LOG2D)) u_pub (
      .clk(clk), .rst_n(rst_n), .clr(1'b0),
      .wr_en(flush && (dst == DST_PUB)), .wr_data(word[MAXW-1 -: PW]), .full(pdi_full),
      .rd_en(pdi_valid && pdi_ready), .rd_data(pdi_data), .empty(pdi_empty),
      .count(pub_cnt_unused));
   assign pdi_valid = !pdi_empty;

   vlw_fifo #(.W(SW), .LOG2D(SEC_LOG2D)) u_sec (
      .clk(clk), .rst_n(rst_n), .clr(1'b0),
      .wr_en(flush && (dst == DST_SEC)), .wr_data(word[MAXW-1 -: SW]), .full(sdi_full),
      .rd_en(sdi_valid && sdi_ready), .rd_data(sdi_data), .empty(sdi_empty),
      .count(sec_cnt_unused));
   assign sdi_valid = !sdi_empty;

   if (RAND_WORDS != 0) begin : g_rnd
      logic               rdi_empty;
      logic [RND_LOG2D:0] rnd_cnt_unused;
      vlw_fifo #(.W(RW), .LOG2D(RND_LOG2D)) u_rnd (
         .clk(clk), .rst_n(rst_n), .clr(1'b0),
         .wr_en(flush && (dst == DST_RND)), .wr_data(word[MAXW-1 -: RW]), .full(rdi_full),
         .rd_en(rdi_valid && rdi_ready), .rd_data(rdi_data), .empty(rdi_empty),
         .count(rnd_cnt_unused));
      assign rdi_valid = !rdi_empty;
   end else begin : g_no_rnd
      logic rnd_in_unused;
      assign rnd_in_unused = rdi_ready;
      assign rdi_data  = '0;
      assign rdi_valid = 1'b0;
      assign rdi_full  = 1'b0;
   end

   assign do_ready = !out_full;

   vlw_fifo #(.W(OW), .LOG2D(OUT_LOG2D)) u_out (
      .clk(clk), .rst_n(rst_n), .clr(unp_fin),
      .wr_en(do_valid && do_ready), .wr_data(do_data), .full(out_full),
      .rd_en(out_pop), .rd_data(out_head), .empty(out_empty), .count(out_cnt));

   vlw_unpack #(.W(OW), .BW(17)) u_unpack (
      .clk(clk), .rst_n(rst_n), .start(unp_start), .budget({exp_bytes, 1'b0}),
      .src_data(out_head), .src_empty(out_empty), .src_pop(out_pop),
      .out_nib(out_nib), .out_valid(out_valid), .out_ready(out_ready), .finished(unp_fin));

   // R6
   load_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> core_rst);
   // R6
   send_while_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !core_rst);
   // R7
   pub_pop_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pdi_valid && pdi_ready) |-> !core_rst);
   // R10
   reset_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !core_rst && unp_fin) |=> core_rst);
endmodule

// File: tb/vector_link_wrapper_test.sv
`timescale 1ns/1ps
module vector_link_wrapper_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [3:0]   in_nib;
   logic         in_valid;
   logic         in_ready;
   logic [3:0]   out_nib;
   logic         out_valid;
   logic         out_ready;
   logic         core_rst;
   logic [127:0] pdi_data;
   logic         pdi_valid, pdi_ready;
   logic [127:0] sdi_data;
   logic         sdi_valid, sdi_ready;
   logic [63:0]  rdi_data;
   logic         rdi_valid;
   logic         rdi_ready;
   logic [127:0] do_data;
   logic         do_valid, do_ready;

   int total = 0;
   int bad   = 0;
   int core_allow = 1000;
   logic [3:0] rx [0:127];
   int hold_errs;

   always #2.5 clk = ~clk;

   vector_link_wrapper uut (
      .clk(clk), .rst_n(rst_n), .in_nib(in_nib), .in_valid(in_valid), .in_ready(in_ready),
      .out_nib(out_nib), .out_valid(out_valid), .out_ready(out_ready), .core_rst(core_rst),
      .pdi_data(pdi_data), .pdi_valid(pdi_valid), .pdi_ready(pdi_ready),
      .sdi_data(sdi_data), .sdi_valid(sdi_valid), .sdi_ready(sdi_ready),
      .rdi_data(rdi_data), .rdi_valid(rdi_valid), .rdi_ready(rdi_ready),
      .do_data(do_data), .do_valid(do_valid), .do_ready(do_ready));

   // core model: takes a public/secret pair, returns their xor as one result word
   logic         busy;
   int           core_made;
   logic [127:0] core_res;
   assign rdi_ready = 1'b0;
   assign pdi_ready = !core_rst && !busy && pdi_valid && sdi_valid;
   assign sdi_ready = pdi_ready;
   assign do_valid  = busy && (core_made < core_allow);
   assign do_data   = core_res;
   always_ff @(posedge clk) begin
      if (core_rst) begin
         busy <= 1'b0; core_made <= 0;
      end else if (pdi_ready) begin
         busy <= 1'b1; core_res <= pdi_data ^ sdi_data;
      end else if (do_valid && do_ready) begin
         busy <= 1'b0; core_made <= core_made + 1;
      end
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [127:0] mkword(input logic [7:0] base, input int nbytes, input int widx);
      logic [127:0] w = '0;
      for (int j = 0; j < 16; j++) begin
         int k = widx*16 + j;
         w[127-8*j -: 8] = (k < nbytes) ? base + 8'(k) : 8'h00;
      end
      return w;
   endfunction

   function automatic logic [127:0] rxword(input int widx);
      logic [127:0] w = '0;
      for (int j = 0; j < 32; j++) w[127-4*j -: 4] = rx[widx*32 + j];
      return w;
   endfunction

   task automatic send_nib(input logic [3:0] n);
      in_valid = 1'b1; in_nib = n;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_cmd(input logic [3:0] hdr, input logic [15:0] len, input logic [7:0] base);
      send_nib(hdr);
      for (int i = 3; i >= 0; i--) send_nib(len[4*i +: 4]);
      if (hdr != 4'h4) begin
         for (int k = 0; k < int'(len); k++) begin
            logic [7:0] b = base + 8'(k);
            send_nib(b[7:4]);
            send_nib(b[3:0]);
         end
      end
   endtask

   task automatic recv(input int n);
      int got = 0; int cyc = 0; logic pend = 1'b0; logic [3:0] pn = '0;
      hold_errs = 0;
      while (got < n && cyc < 5000) begin
         @(negedge clk); cyc++;
         if (pend && !(out_valid && out_nib == pn)) hold_errs++;
         out_ready = (cyc % 3 != 0);
         if (out_valid && out_ready) begin rx[got] = out_nib; got++; pend = 1'b0; end
         else if (out_valid) begin pend = 1'b1; pn = out_nib; end
         else pend = 1'b0;
      end
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; in_nib = '0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 core_rst", 128'(core_rst), 128'(1));
      chk("R1 out_valid", 128'(out_valid), 128'(0));
      chk("R1 in_ready", 128'(in_ready), 128'(1));
      chk("R1 fifo valids", 128'({pdi_valid, sdi_valid, rdi_valid}), 128'(0));
   endtask

   task automatic t_load_pub();
      send_cmd(4'h1, 16'd16, 8'h10);
      chk("R2 pdi_valid", 128'(pdi_valid), 128'(1));
      chk("R2 pdi_data", pdi_data, mkword(8'h10, 16, 0));
      chk("R2 sdi untouched", 128'(sdi_valid), 128'(0));
   endtask

   task automatic t_pad();
      send_cmd(4'h2, 16'd5, 8'hA0);
      chk("R3 sdi_valid", 128'(sdi_valid), 128'(1));
      chk("R3 padded word", sdi_data, mkword(8'hA0, 5, 0));
   endtask

   task automatic t_ignored();
      send_nib(4'h0); send_nib(4'h7); send_nib(4'hF); send_nib(4'h9);
      chk("R4 still loading", 128'({core_rst, in_ready}), 128'(2'b11));
      send_cmd(4'h3, 16'd2, 8'h77);
      chk("R5 rdi_valid", 128'(rdi_valid), 128'(0));
      chk("R4 R5 pdi kept", pdi_data, mkword(8'h10, 16, 0));
      chk("R4 R5 sdi kept", sdi_data, mkword(8'hA0, 5, 0));
   endtask

   task automatic t_run_basic();
      send_cmd(4'h4, 16'd16, 8'h00);
      chk("R6 reset before start", 128'(core_rst), 128'(1));
      send_nib(4'h8);
      chk("R6 core released", 128'(core_rst), 128'(0));
      chk("R6 link closed", 128'(in_ready), 128'(0));
      recv(32);
      chk("R9 R7 result", rxword(0), mkword(8'h10, 16, 0) ^ mkword(8'hA0, 5, 0));
      chk("R9 hold", 128'(hold_errs), 128'(0));
      chk("R10 core_rst back", 128'(core_rst), 128'(1));
      chk("R10 link open", 128'(in_ready), 128'(1));
      chk("R7 inputs drained", 128'({pdi_valid, sdi_valid}), 128'(0));
   endtask

   task automatic t_short();
      int seen = 0;
      send_cmd(4'h1, 16'd32, 8'h30);
      send_cmd(4'h2, 16'd32, 8'h5A);
      send_cmd(4'h4, 16'd3, 8'h00);
      send_nib(4'h8);
      recv(6);
      chk("R9 short count data", {104'h0, rxword(0)[127:104]},
          {104'h0, (mkword(8'h30, 32, 0) ^ mkword(8'h5A, 32, 0))>>104});
      repeat (20) begin @(negedge clk); if (out_valid) seen++; end
      chk("R10 no extra nibbles", 128'(seen), 128'(0));
      chk("R10 core back in reset", 128'(core_rst), 128'(1));
      chk("R7 pairs consumed", 128'(pdi_valid), 128'(0));
   endtask

   task automatic t_threshold();
      core_allow = 1;
      send_cmd(4'h1, 16'd32, 8'h40);
      send_cmd(4'h2, 16'd32, 8'h83);
      send_cmd(4'h4, 16'd32, 8'h00);
      send_nib(4'h8);
      repeat (40) @(negedge clk);
      chk("R8 held below count", 128'(out_valid), 128'(0));
      chk("R8 core still running", 128'(core_rst), 128'(0));
      core_allow = 2;
      recv(64);
      chk("R8 R10 first word", rxword(0), mkword(8'h40, 32, 0) ^ mkword(8'h83, 32, 0));
      chk("R8 second word", rxword(1), mkword(8'h40, 32, 1) ^ mkword(8'h83, 32, 1));
      core_allow = 1000;
   endtask

   task automatic t_backpressure();
      int opened = 0;
      send_nib(4'h1);
      send_nib(4'h0); send_nib(4'h0); send_nib(4'h3); send_nib(4'h0);
      for (int i = 0; i < 95; i++) send_nib(4'(i));
      in_valid = 1'b1; in_nib = 4'h5;
      if (in_ready) opened++;
      repeat (5) begin @(negedge clk); if (in_ready) opened++; end
      chk("R11 stall on full", 128'(opened), 128'(0));
      chk("R11 queue kept", 128'(pdi_valid), 128'(1));
      in_valid = 1'b0;
      do_reset();
      chk("R1 cleared by reset", 128'({core_rst, pdi_valid}), 128'(2'b10));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_load_pub();
      t_pad();
      t_ignored();
      t_run_basic();
      t_short();
      t_threshold();
      t_backpressure();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule